// File: doc/BRIEF.md
# Discharge and Transconductance Auto-Calibrator

This sequencer sets the two 10-bit analog trim codes of a dual-slope converter: the discharge-current trim and the input transconductance trim. It has no converter of its own. It asks the conversion sequencer for measurements and reads back the resulting clock count. The reference voltage is taken as already trimmed before a calibration is requested.

A calibration request starts two searches that always run in the same order. The first search trims the discharge-current code. For each trial code the converter charges the capacitor to its top voltage and counts clocks while it discharges to the lower threshold. The aim is a count of 2^N − 1. The second search starts only after the discharge code is frozen. For each trial code the converter digitises the internal reference channel, and the count is compared with a target code given at an input. The two searches weigh the count in opposite directions. A long discharge means the current is too weak, so that code must rise. A large reference reading means the gain is too strong, so that code must fall.

Each search is a successive approximation from the MSB to the LSB, with one measurement per bit. It stops early if a count equals its target. While the block is idle, either code can also be written directly to bypass the searches.

Top module: `adc_autocal`

## Requirements
- R1: While reset is held and in the first cycle after it, both codes are 0, and `cal_busy`, `cal_done` and `meas_req` are all 0.
- R2: A `cal_req` pulse seen while idle or done makes `cal_busy` 1 in the next cycle. Every discharge measurement (`meas_kind` = 0) comes before every reference measurement (`meas_kind` = 1). `meas_kind` does not change while `meas_req` is held.
- R3: Discharge search, with target 2^ADC_BITS − 1 = 4095. If the count is above the target, or `meas_ovf` is 1, the trial bit is kept. If the count is below the target, the trial bit is cleared.
- R4: Reference search, with target `bg_target`. If the count is above the target, or `meas_ovf` is 1, the trial bit is cleared. If the count is below the target, the trial bit is kept.
- R5: Each search tests bits from the MSB down to the LSB and asks for exactly one measurement per tested bit. The trial code has the tested bit set, the decided bits above it, and zeros below it. A count equal to the target ends the search at once with that trial code as the result. Otherwise the search takes exactly CODE_W measurements.
- R6: The discharge code does not change during the reference search.
- R7: When the reference search ends, `cal_busy` falls and `cal_done` rises in the same cycle. `cal_done` stays 1 until the next accepted `cal_req`. `cal_busy` and `cal_done` are never both 1.
- R8: With the block idle and no `cal_req` in the same cycle, `ovr_wr` loads `ovr_data` into the code picked by `ovr_sel` (0 = discharge, 1 = reference) on the next clock edge. The other code is not changed.
- R9: While `cal_busy` is 1, `ovr_wr` and `cal_req` have no effect: the codes and the measurement sequence go on unchanged.
- R10: `meas_req` stays 1 until `meas_valid` arrives, and is 0 in the cycle after that. A `meas_valid` that arrives while `meas_req` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Pulse that starts a calibration |
| cal_busy | output | 1 | A calibration is running |
| cal_done | output | 1 | The last calibration has finished |
| ovr_wr | input | 1 | Write strobe for a manual code |
| ovr_sel | input | 1 | Code to write: 0 = discharge, 1 = reference |
| ovr_data | input | CODE_W | Manual code value |
| bg_target | input | ADC_BITS+1 | Expected count when the reference channel is converted |
| meas_req | output | 1 | Request for one measurement, held until it is answered |
| meas_kind | output | 1 | 0 = discharge from the top voltage, 1 = reference conversion |
| meas_valid | input | 1 | The measurement result is present |
| meas_count | input | ADC_BITS+1 | Clock count of the measurement |
| meas_ovf | input | 1 | The counter overflowed |
| idc_code | output | CODE_W | Discharge-current trim code |
| gmc_code | output | CODE_W | Transconductance trim code |

## Verification
The assertions check, on every cycle, the local rules of the protocol. A request is held until it is answered and dropped right after. The measurement kind does not change during a request. A trial code does not move while a measurement is pending. The frozen discharge code stays fixed, and the reference code stays fixed during the discharge search. `cal_busy` and `cal_done` are never both 1. Only the bench's sweep can show that each search ends on the right code. The sweep uses a converter model with many offsets, slopes, targets and overflow cases. It also shows that the two search polarities are not swapped, that an exact match shortens the measurement count, and that writes and requests made during a run are ignored.

// File: rtl/adc_autocal_pkg.sv
package adc_autocal_pkg;

    localparam int DEF_CODE_W   = 10;
    localparam int DEF_ADC_BITS = 12;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ID   = 2'd1,
        PH_GM   = 2'd2,
        PH_DONE = 2'd3
    } cal_phase_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_state_e;

    typedef enum logic [1:0] {
        CMP_EQUAL = 2'd0,
        CMP_ABOVE = 2'd1,
        CMP_BELOW = 2'd2
    } cmp_e;

    // An overflowed count is always taken as above the target.
    function automatic cmp_e classify(input logic ovf,
                                      input int unsigned cnt,
                                      input int unsigned tgt);
        if (ovf)        return CMP_ABOVE;
        if (cnt > tgt)  return CMP_ABOVE;
        if (cnt < tgt)  return CMP_BELOW;
        return CMP_EQUAL;
    endfunction

    // A kept bit follows from the comparison and the search polarity.
    function automatic logic keep_bit(input cmp_e c, input logic raise_on_above);
        return (c == CMP_ABOVE) ? raise_on_above : !raise_on_above;
    endfunction

endpackage

// File: rtl/cal_sar_engine.sv
module cal_sar_engine
    import adc_autocal_pkg::*;
#(
    parameter int   CODE_W         = DEF_CODE_W,
    parameter int   CNT_W          = DEF_ADC_BITS + 1,
    parameter logic RAISE_ON_ABOVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ovr_wr,
    input  logic [CODE_W-1:0] ovr_data,
    input  logic              res_valid,
    input  logic              res_ovf,
    input  logic [CNT_W-1:0]  res_count,
    input  logic [CNT_W-1:0]  target,
    output logic [CODE_W-1:0] code,
    output logic              go,
    output logic              finished
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    eng_state_e        st_q;
    logic [IDX_W-1:0]  bit_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] mask;
    logic [CODE_W-1:0] settled;
    cmp_e              verdict;

    assign mask    = CODE_W'(1) << bit_q;
    assign verdict = classify(res_ovf, 32'(res_count), 32'(target));
    assign settled = keep_bit(verdict, RAISE_ON_ABOVE) ? code_q : (code_q & ~mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ENG_IDLE;
            bit_q    <= '0;
            code_q   <= '0;
            go       <= 1'b0;
            finished <= 1'b0;
        end else begin
            go       <= 1'b0;
            finished <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        code_q <= CODE_W'(1) << TOP_IDX;
                        bit_q  <= TOP_IDX;
                        go     <= 1'b1;
                        st_q   <= ENG_WAIT;
                    end else if (ovr_wr) begin
                        code_q <= ovr_data;
                    end
                end
                ENG_WAIT: begin
                    if (res_valid) begin
                        if (verdict == CMP_EQUAL) begin
                            finished <= 1'b1;
                            st_q     <= ENG_IDLE;
                        end else if (bit_q == '0) begin
                            code_q   <= settled;
                            finished <= 1'b1;
                            st_q     <= ENG_IDLE;
                        end else begin
                            code_q <= settled | (mask >> 1);
                            bit_q  <= bit_q - IDX_W'(1);
                            go     <= 1'b1;
                        end
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign code = code_q;

    // R5: a trial code holds while its measurement is outstanding
    p_code_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ENG_WAIT && !res_valid) |=> $stable(code));

endmodule

// File: rtl/cal_meas_link.sv
module cal_meas_link (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic meas_valid,
    output logic meas_req,
    output logic res_valid
);
    always_ff @(posedge clk) begin
        if (rst)             meas_req <= 1'b0;
        else if (go)         meas_req <= 1'b1;
        else if (meas_valid) meas_req <= 1'b0;
    end

    assign res_valid = meas_valid && meas_req;

    // R10: request held until answered
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (meas_req && !meas_valid) |=> meas_req);

    // R10: request released right after the answer
    p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (meas_req && meas_valid) |=> !meas_req);

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import adc_autocal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_req,
    input  logic       id_fin,
    input  logic       gm_fin,
    output logic       start_id,
    output logic       start_gm,
    output cal_phase_e phase,
    output logic       busy,
    output logic       done
);
    cal_phase_e ph_q;
    logic       idle_like;

    assign idle_like = (ph_q == PH_IDLE) || (ph_q == PH_DONE);
    assign start_id  = idle_like && cal_req;
    assign start_gm  = (ph_q == PH_ID) && id_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            case (ph_q)
                PH_IDLE, PH_DONE: if (cal_req) ph_q <= PH_ID;
                PH_ID:            if (id_fin)  ph_q <= PH_GM;
                PH_GM:            if (gm_fin)  ph_q <= PH_DONE;
                default:          ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = ph_q;
    assign busy  = (ph_q == PH_ID) || (ph_q == PH_GM);
    assign done  = (ph_q == PH_DONE);

    // R7: busy and done exclusive
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, done}));

    // R7: done persists until a new request
    p_done_persist_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !cal_req) |=> done);

endmodule

// File: rtl/adc_autocal.sv
module adc_autocal
    import adc_autocal_pkg::*;
#(
    parameter int CODE_W   = DEF_CODE_W,
    parameter int ADC_BITS = DEF_ADC_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_req,
    output logic                cal_busy,
    output logic                cal_done,
    input  logic                ovr_wr,
    input  logic                ovr_sel,
    input  logic [CODE_W-1:0]   ovr_data,
    input  logic [ADC_BITS:0]   bg_target,
    output logic                meas_req,
    output logic                meas_kind,
    input  logic                meas_valid,
    input  logic [ADC_BITS:0]   meas_count,
    input  logic                meas_ovf,
    output logic [CODE_W-1:0]   idc_code,
    output logic [CODE_W-1:0]   gmc_code
);
    localparam int CNT_W   = ADC_BITS + 1;
    localparam int N_CODES = 2;
    localparam logic [CNT_W-1:0] DISCH_TARGET = CNT_W'((1 << ADC_BITS) - 1);

    cal_phase_e        phase;
    logic              start_id, start_gm;
    logic              res_valid;
    logic              ovr_ok;
    logic [N_CODES-1:0] eng_start, eng_go, eng_fin, eng_ovr;
    logic [CODE_W-1:0] eng_code [N_CODES];
    logic [CNT_W-1:0]  eng_tgt  [N_CODES];

    cal_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .cal_req  (cal_req),
        .id_fin   (eng_fin[0]),
        .gm_fin   (eng_fin[1]),
        .start_id (start_id),
        .start_gm (start_gm),
        .phase    (phase),
        .busy     (cal_busy),
        .done     (cal_done)
    );

    assign ovr_ok       = ovr_wr && !cal_busy && !cal_req;
    assign eng_start[0] = start_id;
    assign eng_start[1] = start_gm;
    assign eng_ovr[0]   = ovr_ok && !ovr_sel;
    assign eng_ovr[1]   = ovr_ok && ovr_sel;
    assign eng_tgt[0]   = DISCH_TARGET;
    assign eng_tgt[1]   = bg_target;

    for (genvar g = 0; g < N_CODES; g++) begin : g_eng
        cal_sar_engine #(
            .CODE_W         (CODE_W),
            .CNT_W          (CNT_W),
            .RAISE_ON_ABOVE ((g == 0) ? 1'b1 : 1'b0)
        ) u_eng (
            .clk       (clk),
            .rst       (rst),
            .start     (eng_start[g]),
            .ovr_wr    (eng_ovr[g]),
            .ovr_data  (ovr_data),
            .res_valid (res_valid),
            .res_ovf   (meas_ovf),
            .res_count (meas_count),
            .target    (eng_tgt[g]),
            .code      (eng_code[g]),
            .go        (eng_go[g]),
            .finished  (eng_fin[g])
        );
    end

    cal_meas_link u_link (
        .clk        (clk),
        .rst        (rst),
        .go         (|eng_go),
        .meas_valid (meas_valid),
        .meas_req   (meas_req),
        .res_valid  (res_valid)
    );

    assign meas_kind = (phase == PH_GM);
    assign idc_code  = eng_code[0];
    assign gmc_code  = eng_code[1];

    // R6: discharge code frozen throughout the reference search
    p_id_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GM && $past(phase == PH_GM)) |-> $stable(idc_code));

    // R2: reference code untouched during the discharge search
    p_gm_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ID && $past(phase == PH_ID)) |-> $stable(gmc_code));

    // R2: measurement kind steady during a request
    p_kind_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (meas_req && $past(meas_req)) |-> $stable(meas_kind));

endmodule

// File: tb/test_adc_autocal.sv
module test_adc_autocal;
    localparam int CW   = 10;
    localparam int AB   = 12;
    localparam int CMAX = (1 << (AB + 1)) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cal_req = 1'b0;
    logic          cal_busy, cal_done;
    logic          ovr_wr = 1'b0, ovr_sel = 1'b0;
    logic [CW-1:0] ovr_data = '0;
    logic [AB:0]   bg_target = '0;
    logic          meas_req, meas_kind;
    logic          meas_valid;
    logic [AB:0]   meas_count;
    logic          meas_ovf;
    logic [CW-1:0] idc_code, gmc_code;

    logic        mdl_valid = 1'b0, spur_valid = 1'b0;
    logic [AB:0] mdl_count = '0, spur_count = '0;
    logic        mdl_ovf = 1'b0;

    assign meas_valid = mdl_valid | spur_valid;
    assign meas_count = spur_valid ? spur_count : mdl_count;
    assign meas_ovf   = spur_valid ? 1'b0 : mdl_ovf;

    adc_autocal #(.CODE_W(CW), .ADC_BITS(AB)) i_adc_autocal (
        .clk(clk), .rst(rst), .cal_req(cal_req), .cal_busy(cal_busy),
        .cal_done(cal_done), .ovr_wr(ovr_wr), .ovr_sel(ovr_sel),
        .ovr_data(ovr_data), .bg_target(bg_target), .meas_req(meas_req),
        .meas_kind(meas_kind), .meas_valid(meas_valid),
        .meas_count(meas_count), .meas_ovf(meas_ovf),
        .idc_code(idc_code), .gmc_code(gmc_code));

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    int od = 0, sd = 1, og = 0, sg = 1;
    int n_id = 0, n_gm = 0, order_err = 0;
    int lat = 0;
    logic req_prev = 1'b0;
    logic gm_seen = 1'b0;
    int cyc = 0;
    logic finished = 1'b0;

    function automatic int model(input bit is_id, input int c);
        int v;
        if (is_id) begin v = od - sd * c; if (v < 0) v = 0; end
        else       v = og + sg * c;
        return v;
    endfunction

    // expected final code and measurement count from the requirements
    function automatic void expect_search(input bit is_id, input int tgt,
                                          output int code, output int nmeas);
        int best = 0;
        int exact = -1;
        for (int c = 1; c < (1 << CW); c++) begin
            int v = model(is_id, c);
            if (v == tgt && exact < 0) exact = c;
            if (is_id ? (v > tgt) : (v < tgt)) best = c;
        end
        if (exact > 0) begin
            int tz = 0;
            while (((exact >> tz) & 1) == 0) tz++;
            code  = exact;
            nmeas = CW - tz;
        end else begin
            code  = best;
            nmeas = CW;
        end
    endfunction

    // converter model: answers each request three cycles later
    always @(negedge clk) begin
        if (meas_req && !req_prev) begin
            if (meas_kind) begin n_gm++; gm_seen = 1'b1; end
            else begin n_id++; if (gm_seen) order_err++; end
        end
        req_prev = meas_req;
        if (mdl_valid) begin
            mdl_valid = 1'b0;
            lat = 0;
        end else if (meas_req) begin
            lat++;
            if (lat == 3) begin
                int v;
                v = meas_kind ? model(1'b0, int'(gmc_code)) : model(1'b1, int'(idc_code));
                mdl_ovf   = (v > CMAX);
                mdl_count = (AB+1)'(v);
                mdl_valid = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog expired: actual cycles=%0d expected < 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cal(input bit inject);
        logic [CW-1:0] held;
        int guard;
        n_id = 0; n_gm = 0; order_err = 0; gm_seen = 1'b0;
        @(negedge clk); cal_req = 1'b1;
        @(negedge clk); cal_req = 1'b0;
        chk("R2 busy after request", int'(cal_busy), 1);
        chk("R7 done cleared by request", int'(cal_done), 0);
        if (inject) begin
            guard = 0;
            while (!(meas_kind && meas_req) && guard < 2000) begin @(negedge clk); guard++; end
            held = idc_code;
            ovr_wr = 1'b1; ovr_sel = 1'b0; ovr_data = ~held; cal_req = 1'b1;
            @(negedge clk);
            ovr_wr = 1'b0; cal_req = 1'b0;
            chk("R9 override ignored while busy", int'(idc_code), int'(held));
            chk("R9 still busy", int'(cal_busy), 1);
        end
        guard = 0;
        while (!cal_done && guard < 4000) begin @(negedge clk); guard++; end
        chk("R7 busy low at done", int'(cal_busy), 0);
    endtask

    initial begin
        int eid, egm, nid, ngm, tg;
        repeat (3) @(negedge clk);
        chk("R1 reset idc", int'(idc_code), 0);
        chk("R1 reset busy", int'(cal_busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idc", int'(idc_code), 0);
        chk("R1 gmc", int'(gmc_code), 0);
        chk("R1 busy/done/req", int'({cal_busy, cal_done, meas_req}), 0);

        // R8: manual loads while idle
        ovr_wr = 1'b1; ovr_sel = 1'b0; ovr_data = 10'h155;
        @(negedge clk);
        ovr_sel = 1'b1; ovr_data = 10'h2AA;
        chk("R8 idc loaded", int'(idc_code), 'h155);
        chk("R8 gmc untouched", int'(gmc_code), 0);
        @(negedge clk);
        ovr_wr = 1'b0;
        chk("R8 gmc loaded", int'(gmc_code), 'h2AA);
        chk("R8 idc kept", int'(idc_code), 'h155);

        // R10: stray valid while no request
        spur_count = 13'd5; spur_valid = 1'b1;
        @(negedge clk); spur_valid = 1'b0;
        @(negedge clk);
        chk("R10 stray valid idc", int'(idc_code), 'h155);
        chk("R10 stray valid gmc", int'(gmc_code), 'h2AA);
        chk("R10 stray valid busy", int'(cal_busy), 0);

        for (int s = 0; s < 24; s++) begin
            od = 3000 + 300 * s; sd = 4 + (s % 5);
            og = 100 + 53 * s;   sg = 2 + (s % 7);
            tg = 2000 + 150 * s;
            bg_target = (AB+1)'(tg);
            expect_search(1'b1, (1 << AB) - 1, eid, nid);
            expect_search(1'b0, tg, egm, ngm);
            run_cal(s == 5);
            chk($sformatf("R3 discharge code s=%0d", s), int'(idc_code), eid);
            chk($sformatf("R4 reference code s=%0d", s), int'(gmc_code), egm);
            chk($sformatf("R5 discharge measurements s=%0d", s), n_id, nid);
            chk($sformatf("R5 reference measurements s=%0d", s), n_gm, ngm);
            chk($sformatf("R2 order s=%0d", s), order_err, 0);
            repeat (4) @(negedge clk);
            chk($sformatf("R7 done held s=%0d", s), int'(cal_done), 1);
        end

        // exact-match cases: discharge hits at code 512, reference at 256
        od = 4095 + 3 * 512; sd = 3;
        og = 1000; sg = 4; tg = 1000 + 4 * 256; bg_target = (AB+1)'(tg);
        run_cal(1'b0);
        chk("R5 exact discharge code", int'(idc_code), 512);
        chk("R5 exact discharge single measurement", n_id, 1);
        chk("R5 exact reference code", int'(gmc_code), 256);
        chk("R5 exact reference two measurements", n_gm, 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule